// File: doc/BRIEF.md
# Constant Off-Time Gate Controller

This block times the power switch of a peak-current buck LED driver. When switching is allowed it raises the gate. It holds the gate high until a current-sense comparator reports that the inductor peak has been reached. It then holds the gate low for an off time and raises the gate again. Because the off time is fixed, the switching frequency follows the on time, so the block needs no loop compensation.

After every turn-on, the comparators are masked for a short blanking window. This stops the drain-discharge spike from ending the pulse early. A separate over-current comparator forces a much longer lock-out off time. A dimming input, seen as two comparator flags, gates the switching. When the input is low, the gate is held off. When the input is high, the threshold that follows the dimming voltage is clamped, so only the fixed threshold applies. The off time comes from a count input that is sampled on each gate falling edge. The blanking length and the lock-out length are parameters given in clock cycles.

Top module: `cot_gate_ctrl`

## Requirements
- R1: While the gate is high and blanking has ended, a trip seen at a clock edge drives the gate low at that edge. The value of `toff_cnt_i` present at that same edge sets the off time.
- R2: After a normal trip the gate stays low for exactly `toff_cnt_i` clock cycles and then goes high. A count of 0 behaves as 1.
- R3: For the first `BLANK_CYC` cycles after each gate rising edge, all trip flags are ignored. The shortest on time is therefore `BLANK_CYC` cycles. An on time that ends on a trip lasts max(cycles until trip, `BLANK_CYC`).
- R4: Either the fixed-threshold trip flag or the dimming-threshold trip flag ends the on time (logical OR).
- R5: While `dim_hi_i` is 1, the dimming-threshold trip flag is ignored and only the fixed-threshold flag can end the on time.
- R6: An over-current trip holds the gate low for exactly `OCP_CYC` cycles. When it coincides with a normal trip, it takes priority.
- R7: While `dim_lo_i` is 1, the gate is low from the next edge onward. If the block is idle, the gate rises one cycle after `dim_lo_i` returns to 0.
- R8: `dim_lo_i` does not cancel a running off-time or lock-out timer. If `dim_lo_i` is released before the timer expires, the gate rises exactly when the timer expires.
- R9: Reset forces the gate low asynchronously. `en_i` at 0 forces the gate low at the next edge and clears all timers. The gate rises one cycle after `en_i` goes to 1.
- R10: After a lock-out, the gate restarts with a full blanking window, exactly as after a normal off time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable; 0 stops switching and clears timers |
| cs_ref_trip_i | input | 1 | Sense is above the fixed peak threshold |
| cs_adj_trip_i | input | 1 | Sense is above the threshold derived from the dimming input |
| cs_ocp_trip_i | input | 1 | Sense is above the over-current threshold |
| dim_lo_i | input | 1 | Dimming input is below its low limit (holds the gate off) |
| dim_hi_i | input | 1 | Dimming input is above its high limit (clamps the threshold) |
| toff_cnt_i | input | TOFF_W | Off time in clock cycles, sampled on each falling edge |
| gate_o | output | 1 | Gate drive for the switch |

## Verification
A wrong blanking count changes the width of every pulse that ends early. The error shows on the first on time after any turn-on. A wrong off-time or lock-out count shows within one off period, as a low interval of the wrong length. A state machine that forgets an active lock-out under dimming, or keeps a timer running through a disable, shows as a gate that rises too early in the first cycle after dimming is released or the block is re-enabled.

// File: rtl/cot_gate_pkg.sv
package cot_gate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ON   = 2'd1,
    ST_OFF  = 2'd2,
    ST_LOCK = 2'd3
  } cot_state_e;
endpackage

// File: rtl/cot_trip_merge.sv
module cot_trip_merge (
  input  logic blank_done_i,
  input  logic ref_trip_i,
  input  logic adj_trip_i,
  input  logic adj_clamp_i,
  input  logic ocp_trip_i,
  output logic norm_trip_o,
  output logic ocp_trip_o
);
  // Clamped dimming threshold sits above the fixed one, so its flag is moot.
  always_comb begin
    norm_trip_o = blank_done_i & (ref_trip_i | (adj_trip_i & ~adj_clamp_i));
    ocp_trip_o  = blank_done_i & ocp_trip_i;
  end
endmodule

// File: rtl/cot_blank_timer.sv
module cot_blank_timer #(
  parameter int BLANK_CYC = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic done_o
);
  localparam int BW = (BLANK_CYC > 1) ? $clog2(BLANK_CYC) : 1;
  localparam logic [BW-1:0] LAST = BW'(BLANK_CYC - 1);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);

  a_r3_blank_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> done_o);
endmodule

// File: rtl/cot_off_timer.sv
module cot_off_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tmr_q <= '0;
    else if (clr_i)      tmr_q <= '0;
    else if (load_i)     tmr_q <= load_val_i;
    else if (tmr_q != 0) tmr_q <= tmr_q - 1'b1;
  end

  // Expiring at one makes a count of N give N low cycles; zero acts as one.
  assign expire_o = (tmr_q <= TMR_W'(1));

  a_r2_timer_never_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i) |=> (tmr_q <= $past(tmr_q)));
endmodule

// File: rtl/cot_gate_ctrl.sv
module cot_gate_ctrl
  import cot_gate_pkg::*;
#(
  parameter int BLANK_CYC = 25,
  parameter int OCP_CYC   = 25000,
  parameter int TOFF_W    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cs_ref_trip_i,
  input  logic              cs_adj_trip_i,
  input  logic              cs_ocp_trip_i,
  input  logic              dim_lo_i,
  input  logic              dim_hi_i,
  input  logic [TOFF_W-1:0] toff_cnt_i,
  output logic              gate_o
);
  localparam int OCP_W = $clog2(OCP_CYC + 1);
  localparam int TMR_W = (TOFF_W > OCP_W) ? TOFF_W : OCP_W;

  cot_state_e       state_q, state_d;
  logic             run;
  logic             blank_done, norm_trip, ocp_trip;
  logic             tmr_expire, tmr_load;
  logic [TMR_W-1:0] tmr_val;

  assign run = en_i & ~dim_lo_i;

  cot_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != ST_ON),
    .done_o (blank_done)
  );

  cot_trip_merge u_trip (
    .blank_done_i (blank_done),
    .ref_trip_i   (cs_ref_trip_i),
    .adj_trip_i   (cs_adj_trip_i),
    .adj_clamp_i  (dim_hi_i),
    .ocp_trip_i   (cs_ocp_trip_i),
    .norm_trip_o  (norm_trip),
    .ocp_trip_o   (ocp_trip)
  );

  cot_off_timer #(.TMR_W(TMR_W)) u_toff (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (~en_i),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expire_o   (tmr_expire)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = ocp_trip ? TMR_W'(OCP_CYC) : TMR_W'(toff_cnt_i);
    if (!en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (run) state_d = ST_ON;
        ST_ON: begin
          if (!run) begin
            state_d = ST_IDLE;
          end else if (ocp_trip) begin
            state_d  = ST_LOCK;
            tmr_load = 1'b1;
          end else if (norm_trip) begin
            state_d  = ST_OFF;
            tmr_load = 1'b1;
          end
        end
        ST_OFF, ST_LOCK: if (tmr_expire) state_d = dim_lo_i ? ST_IDLE : ST_ON;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign gate_o = (state_q == ST_ON);

  a_r9_disable_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !gate_o);
  a_r7_dim_low_holds_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dim_lo_i |=> !gate_o);
  a_r1_trip_ends_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && run && norm_trip) |=> !gate_o);
  a_r6_lockout_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCK && !tmr_expire) |=> !gate_o);
  a_r6_ocp_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && run && ocp_trip) |=> (state_q == ST_LOCK));

  if (BLANK_CYC > 1) begin : g_blank_chk
    a_r3_min_on_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(gate_o) && run) |=> gate_o);
  end
endmodule

// File: tb/cot_gate_ctrl_bench.sv
module cot_gate_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK      = 4;
  localparam int OCP        = 40;
  localparam int TW         = 8;

  // {toff, kind, trip_delay, exp_on, exp_off, req}
  // kind: 0 fixed trip, 1 dim trip, 2 dim trip under clamp then fixed trip 3 later,
  //       3 over-current, 4 over-current together with fixed trip
  localparam int NV = 11;
  localparam int VEC [NV][6] = '{
    '{5,   0, 6, 6,   5,   1},  // R1 R2
    '{3,   1, 2, 4,   3,   4},  // R4 R3
    '{1,   0, 1, 4,   1,   3},  // R3
    '{0,   1, 9, 9,   1,   2},  // R2 zero count
    '{7,   2, 5, 8,   7,   5},  // R5
    '{2,   3, 5, 5,   OCP, 6},  // R6
    '{3,   1, 1, 4,   3,   10}, // R10 fresh blank after lock-out
    '{6,   3, 1, 4,   OCP, 6},  // R6 R3
    '{255, 0, 4, 4,   255, 2},  // R2 max count
    '{9,   0, 2, 4,   9,   10}, // R10
    '{4,   4, 5, 5,   OCP, 6}   // R6 priority
  };

  logic clk = 1'b0;
  logic rst_n, en, ref_t, adj_t, ocp_t, dlo, dhi;
  logic [TW-1:0] toff;
  logic gate;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cot_gate_ctrl #(.BLANK_CYC(BLANK), .OCP_CYC(OCP), .TOFF_W(TW)) u_cot_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cs_ref_trip_i(ref_t), .cs_adj_trip_i(adj_t),
    .cs_ocp_trip_i(ocp_t), .dim_lo_i(dlo), .dim_hi_i(dhi), .toff_cnt_i(toff), .gate_o(gate)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_gate(input logic lvl);
    int g = 0;
    while (gate !== lvl && g < 5000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic clear_trips();
    ref_t = 0; adj_t = 0; ocp_t = 0; dhi = 0;
  endtask

  task automatic pulse(input int t, input int kind, input int dly,
                       input int eon, input int eoff, input int req);
    int on_cnt = 0;
    int off_cnt = 0;
    toff = TW'(t);
    wait_gate(1'b1);
    while (gate === 1'b1 && on_cnt < 5000) begin
      on_cnt++;
      if (on_cnt >= dly) begin
        case (kind)
          0: ref_t = 1;
          1: adj_t = 1;
          2: begin adj_t = 1; dhi = 1; if (on_cnt >= dly + 3) ref_t = 1; end
          3: ocp_t = 1;
          default: begin ocp_t = 1; ref_t = 1; end
        endcase
      end
      @(negedge clk);
    end
    clear_trips();
    while (gate === 1'b0 && off_cnt < 5000) begin
      off_cnt++;
      @(negedge clk);
    end
    chk(on_cnt == eon, $sformatf("R%0d on-time", req), on_cnt, eon);
    chk(off_cnt == eoff, $sformatf("R%0d off-time", req), off_cnt, eoff);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lows;
    int highs;
    rst_n = 0; en = 0; dlo = 0; toff = '0;
    clear_trips();
    repeat (3) @(negedge clk);
    chk(gate === 1'b0, "R9 reset low", int'(gate), 0);
    rst_n = 1;
    @(negedge clk);
    chk(gate === 1'b0, "R9 disabled low", int'(gate), 0);
    en = 1;
    @(negedge clk);
    chk(gate === 1'b1, "R9 turn-on one cycle after enable", int'(gate), 1);

    for (int i = 0; i < NV; i++)
      pulse(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5]);

    // R7: dimming low during on time, then release from idle
    wait_gate(1'b1);
    dlo = 1;
    highs = 0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (gate !== 1'b0) highs++;
    end
    chk(highs == 0, "R7 dim low holds gate off", highs, 0);
    dlo = 0;
    @(negedge clk);
    chk(gate === 1'b1, "R7 rise after dim release", int'(gate), 1);

    // R8: dimming low does not cancel a lock-out
    ocp_t = 1;
    wait_gate(1'b0);
    ocp_t = 0;
    dlo = 1;
    lows = 0;
    while (gate === 1'b0 && lows < 5000) begin
      lows++;
      if (lows == 10) dlo = 0;
      @(negedge clk);
    end
    chk(lows == OCP, "R8 lock-out survives dimming", lows, OCP);

    // R9: disable clears a running off timer
    toff = TW'(200);
    ref_t = 1;
    wait_gate(1'b0);
    ref_t = 0;
    repeat (3) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk(gate === 1'b0, "R9 disable low", int'(gate), 0);
    en = 1;
    @(negedge clk);
    chk(gate === 1'b1, "R9 timer cleared by disable", int'(gate), 1);

    // R9: asynchronous reset while on
    #(CLK_PERIOD/4) rst_n = 0;
    #1;
    chk(gate === 1'b0, "R9 async reset", int'(gate), 0);
    @(negedge clk);
    rst_n = 1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule